// File: doc/BRIEF.md
# SDRAM Refresh Timer and Scheduler

This block keeps an SDRAM array refreshed. A 12-bit down-counter runs on the controller clock. Each time it reaches zero, it raises a one-cycle expiry pulse, which serves as the processor interrupt and the transfer-engine event, and reloads from the programmed period. When SDRAM is fitted, each expiry also adds a programmable batch of one to four auto-refreshes to a saturating pending count. Expiries that arrive while a batch is waiting or running are therefore kept.

The block asks the memory arbiter for the command bus. It waits until the arbiter reports that no transfer is still in flight. It then closes every bank with a precharge-all and issues the pending refreshes with programmable spacing. It does not reopen any row afterwards.

A control bit puts the SDRAM into self-refresh when memory is fitted. With no SDRAM, the same bit drives the clock-enable pin directly at the inverted level, and the counter serves as a general periodic timer.

Top module: `sdram_refresh_sched`

## Requirements
- R1: After reset, `count_o` reads 0x5DC and the period is 0x5DC. `cmd_o` is 0 (no-op), `rfsh_req_o` is 0 and `tick_o` is 0. With `self_refresh_i` low, `cke_o` is 1.
- R2: `count_o` falls by one on every clock. In the cycle after it reads 0, it reads the period again, so expiries are period+1 cycles apart.
- R3: `tick_o` is high for exactly the cycles in which `count_o` is 0. This holds whatever the value of `sdram_en_i`.
- R4: A cycle with `cfg_we_i` high loads `cfg_period_i` into both the period and the count, visible on the next cycle. A written period of 0 behaves as 1.
- R5: With `sdram_en_i` high, each expiry schedules `cfg_mult_i`+1 refreshes, using the multiplier value stored by the last `cfg_we_i`. Codes 0..3 give 1..4 refreshes. Once the batch is done, `rfsh_req_o` falls.
- R6: `rfsh_req_o` is high while refresh work is owed. No command is issued while `arb_busy_i` is high. Precharge-all appears in the cycle after `arb_busy_i` is sampled low with the request high.
- R7: A batch is one precharge-all, with the first refresh `trp` cycles after it and each further refresh `trfc` cycles after the previous one. `cmd_o` codes are 0 no-op, 1 precharge-all, 2 auto-refresh and 3 self-refresh entry.
- R8: Expiries that occur while refreshes are still owed are added to the pending count, so every refresh is issued. This includes an expiry that falls in the same cycle as a refresh issue. The pending count saturates at 15 by default.
- R9: With `sdram_en_i` low, no request and no command is produced, while the timer and `tick_o` keep running. In this case `cke_o` equals the inverse of `self_refresh_i`.
- R10: With `sdram_en_i` and `self_refresh_i` both high, the block issues precharge-all and then self-refresh entry `trp` cycles later, with `cke_o` falling in the same cycle. `cke_o` stays low and no refresh is issued until `self_refresh_i` clears. `cke_o` then returns high on the next cycle.
- R11: `gap_we_i` writes `trp` and `trfc`, whose reset values are 3 and 8. A gap written as 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for period and multiplier |
| cfg_period_i | input | 12 | Refresh period in clocks |
| cfg_mult_i | input | 2 | Refreshes per expiry minus one |
| gap_we_i | input | 1 | Write strobe for the command gaps |
| gap_trp_i | input | 4 | Precharge-to-refresh gap in clocks |
| gap_trfc_i | input | 4 | Refresh-to-refresh gap in clocks |
| sdram_en_i | input | 1 | SDRAM fitted; enables refresh generation |
| self_refresh_i | input | 1 | Self-refresh request, or clock-enable output level when no SDRAM |
| arb_busy_i | input | 1 | Arbiter has a transfer in flight |
| count_o | output | 12 | Live counter value |
| tick_o | output | 1 | Expiry pulse (interrupt/event) |
| rfsh_req_o | output | 1 | Request for, and hold of, the command bus |
| cmd_o | output | 2 | Command issued this cycle |
| cke_o | output | 1 | SDRAM clock enable |

## Verification
A timer expiry and a refresh issue can fall in the same clock. One then increments the pending count while the other decrements it. The bench provokes this by setting the period to 10, the multiplier to four refreshes and the refresh gap to 7. With those values the second expiry lands exactly on the edge that issues the second refresh. The scoreboard then expects a single precharge-all and exactly eight refreshes at the programmed spacing, so a lost increment or a lost decrement shows up as a missing or an extra command.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_PREA = 2'd1,
    CMD_REF  = 2'd2,
    CMD_SREF = 2'd3
  } rfsh_cmd_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_PGAP,
    S_RGAP,
    S_SR
  } rfsh_state_e;
endpackage

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
  parameter int unsigned CNT_W = 12,
  parameter logic [CNT_W-1:0] RST_PERIOD = 12'h5DC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] period_q, count_q, period_eff;

  // zero period would pin the counter at zero
  assign period_eff = (period_i == '0) ? CNT_W'(1) : period_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= RST_PERIOD;
      count_q  <= RST_PERIOD;
    end else if (load_i) begin
      period_q <= period_eff;
      count_q  <= period_eff;
    end else if (count_q == '0) begin
      count_q <= period_q;
    end else begin
      count_q <= count_q - 1'b1;
    end
  end

  assign count_o  = count_q;
  assign expire_o = (count_q == '0);

  assert_reload_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == '0 && !load_i) |=> count_q == $past(period_q));
  assert_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !expire_o);
  assert_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (count_q != '0 && count_q == period_q));
endmodule

// File: rtl/rfsh_pending.sv
module rfsh_pending #(
  parameter int unsigned PEND_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              add_i,
  input  logic [2:0]        amt_i,
  input  logic              dec_i,
  output logic [PEND_W-1:0] pend_o,
  output logic              nonzero_o
);
  localparam logic [PEND_W-1:0] MAX_P   = '1;
  localparam logic [PEND_W+2:0] MAX_EXT = {3'b000, MAX_P};

  logic [PEND_W-1:0] pend_q;
  logic [PEND_W+2:0] sum;
  logic [PEND_W+2:0] head;

  always_comb begin
    sum = {3'b000, pend_q} + (add_i ? {{PEND_W{1'b0}}, amt_i} : '0);
    if (dec_i && sum != '0) sum = sum - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            pend_q <= '0;
    else if (sum > MAX_EXT) pend_q <= MAX_P;
    else                    pend_q <= sum[PEND_W-1:0];
  end

  assign pend_o    = pend_q;
  assign nonzero_o = (pend_q != '0);
  assign head      = {3'b000, pend_q} + (PEND_W+3)'(4);

  assert_dec_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !add_i) |=> pend_q == $past(pend_q) - 1'b1);
  assert_add_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_i && !dec_i && head <= MAX_EXT) |=>
      pend_q == $past(pend_q) + PEND_W'($past(amt_i)));
  assert_sat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_i && pend_q == MAX_P) |=> pend_q == MAX_P);
endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
  import rfsh_pkg::*;
#(
  parameter int unsigned GAP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sdram_en_i,
  input  logic             sr_i,
  input  logic             pend_nz_i,
  input  logic             busy_i,
  input  logic [GAP_W-1:0] trp_i,
  input  logic [GAP_W-1:0] trfc_i,
  output logic             req_o,
  output rfsh_cmd_e        cmd_o,
  output logic             cke_o,
  output logic             dec_o
);
  rfsh_state_e      state_q, state_d;
  rfsh_cmd_e        cmd_q, cmd_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic             cke_q, cke_d;
  logic             want;

  function automatic logic [GAP_W-1:0] gap_ld(input logic [GAP_W-1:0] g);
    return (g == '0) ? '0 : g - 1'b1;
  endfunction

  assign want = sdram_en_i && (pend_nz_i || sr_i);

  always_comb begin
    state_d = state_q;
    cmd_d   = CMD_NOP;
    gap_d   = gap_q;
    cke_d   = cke_q;
    dec_o   = 1'b0;
    unique case (state_q)
      S_IDLE: if (want && !busy_i) begin
        cmd_d   = CMD_PREA;
        gap_d   = gap_ld(trp_i);
        state_d = S_PGAP;
      end
      S_PGAP: begin
        if (gap_q != '0) gap_d = gap_q - 1'b1;
        else if (sdram_en_i && sr_i) begin
          cmd_d   = CMD_SREF;
          cke_d   = 1'b0;
          state_d = S_SR;
        end else if (pend_nz_i) begin
          cmd_d   = CMD_REF;
          dec_o   = 1'b1;
          gap_d   = gap_ld(trfc_i);
          state_d = S_RGAP;
        end else state_d = S_IDLE;
      end
      S_RGAP: begin
        if (gap_q != '0) gap_d = gap_q - 1'b1;
        else if (pend_nz_i && sdram_en_i && !sr_i) begin
          cmd_d = CMD_REF;
          dec_o = 1'b1;
          gap_d = gap_ld(trfc_i);
        end else state_d = S_IDLE;
      end
      S_SR: if (!sr_i) begin
        cke_d   = 1'b1;
        gap_d   = gap_ld(trfc_i);
        state_d = S_RGAP;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cmd_q   <= CMD_NOP;
      gap_q   <= '0;
      cke_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      gap_q   <= gap_d;
      cke_q   <= cke_d;
    end
  end

  assign req_o = (state_q != S_IDLE) || want;
  assign cmd_o = cmd_q;
  assign cke_o = cke_q;

  assert_grant_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_PREA) |-> $past(req_o && !busy_i));
  assert_busy_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && busy_i) |=> cmd_q == CMD_NOP);
  assert_disabled_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && !sdram_en_i) |=> cmd_q == CMD_NOP);
  assert_sref_cke_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_SREF) |-> !cke_q);
  assert_no_ref_in_sr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_q) |-> cmd_q != CMD_REF);
endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
  import rfsh_pkg::*;
#(
  parameter int unsigned CNT_W    = 12,
  parameter int unsigned PEND_W   = 4,
  parameter int unsigned GAP_W    = 4,
  parameter logic [CNT_W-1:0] RST_PERIOD = 12'h5DC,
  parameter logic [GAP_W-1:0] RST_TRP    = 4'd3,
  parameter logic [GAP_W-1:0] RST_TRFC   = 4'd8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CNT_W-1:0] cfg_period_i,
  input  logic [1:0]       cfg_mult_i,
  input  logic             gap_we_i,
  input  logic [GAP_W-1:0] gap_trp_i,
  input  logic [GAP_W-1:0] gap_trfc_i,
  input  logic             sdram_en_i,
  input  logic             self_refresh_i,
  input  logic             arb_busy_i,
  output logic [CNT_W-1:0] count_o,
  output logic             tick_o,
  output logic             rfsh_req_o,
  output logic [1:0]       cmd_o,
  output logic             cke_o
);
  logic [1:0]        mult_q;
  logic [GAP_W-1:0]  trp_q, trfc_q;
  logic              expire, dec, pend_nz, seq_cke;
  logic [PEND_W-1:0] pend;
  rfsh_cmd_e         seq_cmd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mult_q <= '0;
      trp_q  <= RST_TRP;
      trfc_q <= RST_TRFC;
    end else begin
      if (cfg_we_i) mult_q <= cfg_mult_i;
      if (gap_we_i) begin
        trp_q  <= gap_trp_i;
        trfc_q <= gap_trfc_i;
      end
    end
  end

  rfsh_timer #(.CNT_W(CNT_W), .RST_PERIOD(RST_PERIOD)) u_timer (
    .clk_i, .rst_ni,
    .load_i   (cfg_we_i),
    .period_i (cfg_period_i),
    .count_o  (count_o),
    .expire_o (expire)
  );

  rfsh_pending #(.PEND_W(PEND_W)) u_pend (
    .clk_i, .rst_ni,
    .add_i     (expire && sdram_en_i),
    .amt_i     ({1'b0, mult_q} + 3'd1),
    .dec_i     (dec),
    .pend_o    (pend),
    .nonzero_o (pend_nz)
  );

  rfsh_seq #(.GAP_W(GAP_W)) u_seq (
    .clk_i, .rst_ni,
    .sdram_en_i (sdram_en_i),
    .sr_i       (self_refresh_i),
    .pend_nz_i  (pend_nz),
    .busy_i     (arb_busy_i),
    .trp_i      (trp_q),
    .trfc_i     (trfc_q),
    .req_o      (rfsh_req_o),
    .cmd_o      (seq_cmd),
    .cke_o      (seq_cke),
    .dec_o      (dec)
  );

  assign tick_o = expire;
  assign cmd_o  = seq_cmd;
  // without SDRAM the pin is a plain inverted output
  assign cke_o  = sdram_en_i ? seq_cke : ~self_refresh_i;

  assert_tick_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> count_o == '0);
  assert_dec_owed_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec |-> pend != '0);
endmodule

// File: tb/sdram_refresh_sched_tb.sv
module sdram_refresh_sched_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 0, gap_we = 0, sdram_en = 0, sr = 0, busy = 0;
  logic [11:0] cfg_period = '0;
  logic [1:0]  cfg_mult = '0;
  logic [3:0]  trp = '0, trfc = '0;
  logic [11:0] count;
  logic        tick, req, cke;
  logic [1:0]  cmd;

  always #2.5 clk = ~clk;

  sdram_refresh_sched u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_period_i(cfg_period), .cfg_mult_i(cfg_mult),
    .gap_we_i(gap_we), .gap_trp_i(trp), .gap_trfc_i(trfc),
    .sdram_en_i(sdram_en), .self_refresh_i(sr), .arb_busy_i(busy),
    .count_o(count), .tick_o(tick), .rfsh_req_o(req), .cmd_o(cmd), .cke_o(cke)
  );

  localparam logic [1:0] NOP = 2'd0, PREA = 2'd1, REF = 2'd2, SREF = 2'd3;

  int n_cmp = 0, n_bad = 0;
  int cyc = 0;
  int last_tick = 0, last_cmd = 0;
  bit saw_req = 0, done = 0;
  logic [1:0] exp_cmd_q[$];
  int         exp_gap_q[$];
  bit         exp_ft_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
    end
  endtask

  task automatic push(input logic [1:0] c, input int gap, input bit ft);
    exp_cmd_q.push_back(c);
    exp_gap_q.push_back(gap);
    exp_ft_q.push_back(ft);
  endtask

  // monitor: pops expected commands and compares type and spacing
  always @(negedge clk) if (rst_n) begin
    if (req) saw_req <= 1'b1;
    if (tick) last_tick = cyc;
    if (cmd != NOP) begin
      if (exp_cmd_q.size() == 0) chk(0, "R5/R9 unexpected cmd", cmd, 0);
      else begin
        automatic logic [1:0] ec = exp_cmd_q.pop_front();
        automatic int eg = exp_gap_q.pop_front();
        automatic bit ft = exp_ft_q.pop_front();
        automatic int ag = cyc - (ft ? last_tick : last_cmd);
        chk(cmd == ec, "R7 cmd type", cmd, ec);
        if (eg >= 0) chk(ag == eg, "R7/R11 cmd spacing", ag, eg);
      end
      last_cmd = cyc;
    end
  end

  task automatic cfg_write(input int p, input int m);
    @(negedge clk);
    cfg_we = 1; cfg_period = 12'(p); cfg_mult = 2'(m);
    @(negedge clk);
    cfg_we = 0;
    chk(count == ((p == 0) ? 1 : p), "R4 count load", count, (p == 0) ? 1 : p);
  endtask

  task automatic gap_write(input int a, input int b);
    @(negedge clk);
    gap_we = 1; trp = 4'(a); trfc = 4'(b);
    @(negedge clk);
    gap_we = 0;
  endtask

  task automatic wait_tick(output int t);
    int k;
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!tick && k < 6000);
    chk(tick, "R2 expiry seen", tick, 1);
    t = cyc;
  endtask

  task automatic drain();
    int k;
    k = 0;
    while (exp_cmd_q.size() != 0 && k < 3000) begin
      @(negedge clk);
      k++;
    end
    chk(exp_cmd_q.size() == 0, "R5/R7 expected cmds issued", exp_cmd_q.size(), 0);
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int t1, t2;
    bit quiet;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #0;
    chk(count == 12'h5DC, "R1 reset count", count, 12'h5DC);
    chk(cmd == NOP, "R1 reset cmd", cmd, NOP);
    chk(req == 0, "R1 reset req", req, 0);
    chk(cke == 1, "R1 reset cke", cke, 1);
    chk(tick == 0, "R1 reset tick", tick, 0);
    @(negedge clk);
    chk(count == 12'h5DB, "R2 decrement", count, 12'h5DB);

    // timer only, SDRAM absent
    cfg_write(20, 0);
    wait_tick(t1);
    chk(count == 0, "R3 tick at zero", count, 0);
    @(negedge clk);
    chk(tick == 0, "R3 one-cycle pulse", tick, 0);
    chk(count == 20, "R2 reload", count, 20);
    wait_tick(t2);
    chk(t2 - t1 == 21, "R2 expiry interval", t2 - t1, 21);
    chk(saw_req == 0, "R9 no request when disabled", saw_req, 0);
    sr = 1; #1;
    chk(cke == 0, "R9 cke inverted gpo", cke, 0);
    sr = 0; #1;
    chk(cke == 1, "R9 cke inverted gpo", cke, 1);

    // zero period behaves as one
    cfg_write(0, 0);
    wait_tick(t1);
    wait_tick(t2);
    chk(t2 - t1 == 2, "R4 zero period interval", t2 - t1, 2);

    // two refreshes, reset gaps (R5, R7, R11 defaults)
    cfg_write(4000, 1);
    sdram_en = 1;
    cfg_write(40, 1);
    push(PREA, 2, 1); push(REF, 3, 0); push(REF, 8, 0);
    wait_tick(t1);
    cfg_write(4000, 1);
    drain();
    chk(req == 0, "R5 request released", req, 0);

    // arbiter busy, zero gaps (R6, R11)
    busy = 1;
    gap_write(0, 0);
    cfg_write(30, 1);
    push(PREA, -1, 0); push(REF, 1, 0); push(REF, 1, 0);
    wait_tick(t1);
    cfg_write(4000, 1);
    chk(req == 1, "R6 request held while busy", req, 1);
    quiet = 1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (cmd != NOP) quiet = 0;
    end
    chk(quiet, "R6 no cmd while busy", quiet, 1);
    busy = 0;
    @(negedge clk);
    chk(cmd == PREA, "R6 precharge after release", cmd, PREA);
    drain();

    // expiry lands on a refresh issue edge (R8)
    gap_write(3, 7);
    cfg_write(10, 3);
    push(PREA, 2, 1); push(REF, 3, 0);
    for (int i = 0; i < 7; i++) push(REF, 7, 0);
    wait_tick(t1);
    wait_tick(t2);
    cfg_write(4000, 3);
    drain();

    // saturation: five expiries of four while blocked -> 15 (R8)
    busy = 1;
    cfg_write(10, 3);
    push(PREA, -1, 0); push(REF, 3, 0);
    for (int i = 0; i < 14; i++) push(REF, 7, 0);
    for (int i = 0; i < 5; i++) wait_tick(t1);
    cfg_write(4000, 3);
    busy = 0;
    drain();

    // self-refresh (R10)
    sr = 1;
    push(PREA, -1, 0); push(SREF, 3, 0);
    drain();
    chk(cke == 0, "R10 cke low in self-refresh", cke, 0);
    chk(req == 1, "R10 bus held in self-refresh", req, 1);
    sr = 0;
    @(negedge clk);
    chk(cke == 1, "R10 cke restored", cke, 1);
    repeat (20) @(negedge clk);
    chk(req == 0, "R10 idle after exit", req, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule